// File: doc/BRIEF.md
# Power Output Controller with Shutdown Re-Assert Delay

This block drives a single power-control output from the combined, already-conditioned wake inputs and an override input. Firmware can take the output over with an enable bit. While that bit is set, a firmware-written level replaces the hardware decision.

A system-shutdown request is active-low. Its falling edge forces the hardware output low and starts a millisecond timer, which counts pulses of a 1 kHz tick. Once the programmed number of ticks has been counted, the output is driven high again for as long as the shutdown request remains active. A programmed delay of zero skips the timer, so the output re-asserts at once. A non-zero delay is held to the legal window of 125 to 32000 ms, and a value outside that window is moved to the nearer bound. If the request is released and then asserted again, the timer restarts from the full delay.

The output level is registered and can be read back directly. A registered copy of the override input is also provided for readback.

Top module: `pwr_out_ctl`

## Requirements
- R1: After synchronous reset, `pin_out` and `ovrd_rd` are both 0.
- R2: While `fw_en` is 1, `pin_out` equals `fw_val` one clock later, whatever the wake, override and shutdown inputs are.
- R3: While `fw_en` is 0 and `shdn_n` is 1, `pin_out` equals `wake_any | ovrd_in` one clock later, and `fw_val` has no effect.
- R4: When `shdn_n` falls with a non-zero delay N (after range limiting), and `fw_en` is 0, `pin_out` is 0 from the next clock on. It stays 0 until N tick pulses have been seen in the cycles after the falling edge. It is 1 from the second clock after the Nth tick, and stays 1 while `shdn_n` stays 0.
- R5: When `dly_ms` is 0, `pin_out` is 1 from the clock after `shdn_n` falls.
- R6: A non-zero `dly_ms` below 125 behaves as 125 ticks.
- R7: A `dly_ms` above 32000 behaves as 32000 ticks.
- R8: If `shdn_n` returns to 1 before the delay ends and falls again, the count restarts from the full delay.
- R9: `ovrd_rd` equals `ovrd_in` one clock later.
- R10: When `shdn_n` returns to 1, `pin_out` follows `wake_any | ovrd_in` again from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_any | input | 1 | OR of enabled, conditioned wake inputs |
| ovrd_in | input | 1 | Override input |
| shdn_n | input | 1 | Shutdown request, active low |
| fw_en | input | 1 | Firmware takeover of the output |
| fw_val | input | 1 | Firmware-written output level |
| dly_ms | input | 16 | Re-assert delay in milliseconds, 0 = none |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz |
| pin_out | output | 1 | Registered power-control output |
| ovrd_rd | output | 1 | Registered readback of the override input |

## Verification
A timer count that is wrong by even one tick shows at the port. `pin_out` then rises one tick too early or too late relative to the Nth pulse, so the bench samples it just before and just after that pulse. A missing restart shows as an early rise during a second shutdown. A stale done flag shows as `pin_out` staying high the cycle after release. Every such fault appears within two clocks of the event that exposes it.

// File: rtl/pwr_dly_pkg.sv
package pwr_dly_pkg;
  localparam int DLY_W  = 16;
  localparam int MIN_MS = 125;
  localparam int MAX_MS = 32000;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/dly_range_clamp.sv
module dly_range_clamp
  import pwr_dly_pkg::*;
#(
  parameter int W  = DLY_W,
  parameter int LO = MIN_MS,
  parameter int HI = MAX_MS
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] lim,
  output logic         is_zero
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    is_zero = (raw == '0);
    if (is_zero)        lim = '0;
    else if (raw < LO_V) lim = LO_V;
    else if (raw > HI_V) lim = HI_V;
    else                 lim = raw;
  end
endmodule

// File: rtl/ms_hold_timer.sv
module ms_hold_timer
  import pwr_dly_pkg::*;
#(
  parameter int W  = DLY_W,
  parameter int LO = MIN_MS,
  parameter int HI = MAX_MS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shdn_act,
  input  logic         tick,
  input  logic [W-1:0] load,
  input  logic         zero,
  output logic         start,
  output logic         running,
  output logic         done
);
  logic         prev;
  logic [W-1:0] cnt;

  assign start = shdn_act & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      prev <= shdn_act;
      if (start) begin
        cnt     <= load;
        running <= ~zero;
        done    <= zero;
      end else if (!shdn_act) begin
        running <= 1'b0;
        done    <= 1'b0;
      end else if (running && tick) begin
        if (cnt == W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  // R4
  run_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt != '0 && cnt <= W'(HI)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !zero) |=> (running && !done && cnt >= W'(LO)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!shdn_act && !start) |=> (!running && !done));
endmodule

// File: rtl/pwr_out_ctl.sv
module pwr_out_ctl
  import pwr_dly_pkg::*;
#(
  parameter int W  = DLY_W,
  parameter int LO = MIN_MS,
  parameter int HI = MAX_MS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wake_any,
  input  logic         ovrd_in,
  input  logic         shdn_n,
  input  logic         fw_en,
  input  logic         fw_val,
  input  logic [W-1:0] dly_ms,
  input  logic         tick_1k,
  output logic         pin_out,
  output logic         ovrd_rd
);
  logic [W-1:0] lim;
  logic         is_zero, start, running, done, shdn_act, hw_lvl;

  assign shdn_act = ~shdn_n;

  dly_range_clamp #(.W(W), .LO(LO), .HI(HI)) u_clamp (
    .raw(dly_ms), .lim(lim), .is_zero(is_zero)
  );

  ms_hold_timer #(.W(W), .LO(LO), .HI(HI)) u_tmr (
    .clk(clk), .rst(rst), .shdn_act(shdn_act), .tick(tick_1k),
    .load(lim), .zero(is_zero), .start(start), .running(running), .done(done)
  );

  always_comb begin
    if (shdn_act) hw_lvl = done | (start & is_zero);
    else          hw_lvl = wake_any | ovrd_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      ovrd_rd <= 1'b0;
    end else begin
      pin_out <= fw_en ? fw_val : hw_lvl;
      ovrd_rd <= ovrd_in;
    end
  end

  // R2
  fw_take_chk: assert property (@(posedge clk) disable iff (rst)
    fw_en |=> (pin_out == $past(fw_val)));

  // R4
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!fw_en && shdn_act && running) |=> !pin_out);

  // R9
  ovrd_copy_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ovrd_rd == $past(ovrd_in)));

  // R6
  clamp_rng_chk: assert property (@(posedge clk) disable iff (rst)
    is_zero || (lim >= W'(LO) && lim <= W'(HI)));
endmodule

// File: tb/pwr_out_ctl_test.sv
module pwr_out_ctl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic wake_any = 0, ovrd_in = 0, shdn_n = 1, fw_en = 0, fw_val = 0, tick_1k = 0;
  logic [15:0] dly_ms = 16'd0;
  logic pin_out, ovrd_rd;
  int checks = 0, errors = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  pwr_out_ctl uut (
    .clk(clk), .rst(rst), .wake_any(wake_any), .ovrd_in(ovrd_in), .shdn_n(shdn_n),
    .fw_en(fw_en), .fw_val(fw_val), .dly_ms(dly_ms), .tick_1k(tick_1k),
    .pin_out(pin_out), .ovrd_rd(ovrd_rd)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    tick_1k = 1;
    cyc(n);
    tick_1k = 0;
  endtask

  task automatic go_idle();
    shdn_n = 1; fw_en = 0; wake_any = 0; ovrd_in = 0; tick_1k = 0;
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 pin_out", pin_out, 1'b0);
    chk("R1 ovrd_rd", ovrd_rd, 1'b0);
  endtask

  task automatic t_fw();
    fw_en = 1; fw_val = 1; wake_any = 0; ovrd_in = 0; cyc(1);
    chk("R2 fw high", pin_out, 1'b1);
    fw_val = 0; wake_any = 1; ovrd_in = 1; cyc(1);
    chk("R2 fw low over wake", pin_out, 1'b0);
    shdn_n = 0; fw_val = 1; dly_ms = 16'd300; cyc(2);
    chk("R2 fw over shutdown", pin_out, 1'b1);
    go_idle();
  endtask

  task automatic t_hw();
    fw_val = 1; wake_any = 0; ovrd_in = 0; cyc(1);
    chk("R3 fw_val ignored", pin_out, 1'b0);
    wake_any = 1; cyc(1);
    chk("R3 wake", pin_out, 1'b1);
    wake_any = 0; ovrd_in = 1; cyc(1);
    chk("R3 ovrd", pin_out, 1'b1);
    chk("R9 ovrd_rd high", ovrd_rd, 1'b1);
    ovrd_in = 0; cyc(1);
    chk("R9 ovrd_rd low", ovrd_rd, 1'b0);
    fw_val = 0;
  endtask

  // assert shutdown, then count n-1 ticks (low), one more (high after 2 clocks)
  task automatic t_delay(string req, logic [15:0] d, int n);
    wake_any = 1; dly_ms = d; shdn_n = 0; cyc(1);
    chk({req, " low at assert"}, pin_out, 1'b0);
    ticks(n - 1);
    chk({req, " low before last tick"}, pin_out, 1'b0);
    ticks(1);
    cyc(1);
    chk({req, " high after delay"}, pin_out, 1'b1);
    wake_any = 0; cyc(3);
    chk({req, " held high"}, pin_out, 1'b1);
    go_idle();
  endtask

  task automatic t_zero();
    dly_ms = 16'd0; shdn_n = 0; cyc(1);
    chk("R5 zero delay high", pin_out, 1'b1);
    go_idle();
  endtask

  task automatic t_restart();
    dly_ms = 16'd200; shdn_n = 0; cyc(1);
    ticks(150);
    chk("R8 low mid delay", pin_out, 1'b0);
    shdn_n = 1; wake_any = 1; cyc(1);
    chk("R10 follows wake on release", pin_out, 1'b1);
    shdn_n = 0; cyc(1);
    chk("R8 low on reassert", pin_out, 1'b0);
    ticks(199);
    chk("R8 still low after restart", pin_out, 1'b0);
    ticks(1); cyc(1);
    chk("R8 high after full delay", pin_out, 1'b1);
    shdn_n = 1; wake_any = 0; cyc(1);
    chk("R10 low on release", pin_out, 1'b0);
    go_idle();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst = 0;
    cyc(1);
    t_reset();
    t_fw();
    t_hw();
    t_delay("R4", 16'd130, 130);
    t_delay("R6", 16'd5, 125);
    t_delay("R7", 16'd40000, 32000);
    t_zero();
    t_restart();
    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule